// File: doc/BRIEF.md
# Ordered Posted-Write Buffer with I/O Fencing

This block sits between a core's request port and a single external bus master port. It holds up to four posted writes and sends them to the bus strictly in the order they were accepted. For each incoming request it decides three things: whether the request is posted, whether it may overtake writes that are still pending, and how long the core must wait. Only one bus transaction is in flight at any time.

The core drives a request with `core_valid` and keeps every request field stable until it sees `core_done` high in some cycle. The request retires at the rising edge that ends that cycle. Memory writes are posted. They are acknowledged in the cycle they are presented, unless the buffer is full. A cacheable memory read whose address matches no buffered write overtakes the buffered writes once the bus is free. Every other read waits until the buffer is empty: I/O reads, non-cacheable reads and reads that match a buffered address. A single I/O write is never posted. The core waits until that write has completed on the bus. I/O writes that belong to a repeated string are posted, except for the last element of the string, which behaves like a single I/O write. As a result, the core is released only after the whole string has reached the bus.

On the bus side, a transaction completes in a cycle where `bus_req` and `bus_ready` are both high.

Top module: `post_wr_fence`

## Requirements
- R1: While reset is held and after it is released, `bus_req` and `core_done` are low and the buffer holds no entry. The first read issued after reset reaches the bus with no write in front of it.
- R2: A memory write (`core_write`=1, `core_io`=0) is acknowledged in the same cycle it is presented while fewer than four writes are pending. The number of pending writes never exceeds four.
- R3: Buffered writes appear on the bus with `bus_we`=1, carrying their address and data, in the order in which they were acknowledged.
- R4: A memory read with `core_cacheable`=1 whose address matches no pending write is issued ahead of the pending writes as soon as the bus is idle. `core_done` is high in the cycle the bus completes it, and `core_rdata` then equals `bus_rdata`.
- R5: A cacheable memory read whose address equals the address of any pending write is issued only after every pending write has completed.
- R6: A memory read with `core_cacheable`=0 is issued only after every pending write has completed.
- R7: An I/O read (`core_io`=1, `core_write`=0) is issued only after every pending write has completed.
- R8: An I/O write with `core_rep`=0 is not buffered. It is issued after every pending write has completed, and `core_done` is high exactly in the cycle the bus completes it.
- R9: An I/O write with `core_rep`=1 and `core_last`=0 is posted and acknowledged at once. An I/O write with `core_rep`=1 and `core_last`=1 is not acknowledged until it has completed on the bus behind all earlier writes.
- R10: While four writes are pending, a new memory write is not acknowledged. It is acknowledged in the cycle after the oldest write completes on the bus.
- R11: Once `bus_req` rises, it stays high with a stable `bus_addr` and `bus_we` until `bus_ready`. In the cycle after a completion, `bus_req` is low.
- R12: A read that may overtake never interrupts a write already on the bus. It is issued after that write completes and before the next buffered write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| core_valid | input | 1 | Core request present; held until `core_done` |
| core_write | input | 1 | 1 = write, 0 = read |
| core_io | input | 1 | 1 = I/O space, 0 = memory space |
| core_rep | input | 1 | Write belongs to a repeated string |
| core_last | input | 1 | Final element of a repeated string |
| core_cacheable | input | 1 | Read targets a cacheable region |
| core_addr | input | AW | Request address |
| core_wdata | input | DW | Write data |
| core_done | output | 1 | Request retires at the end of this cycle |
| core_rdata | output | DW | Read data, valid while `core_done` is high for a read |
| bus_req | output | 1 | Bus transaction requested |
| bus_we | output | 1 | 1 = bus write |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | DW | Bus write data |
| bus_rdata | input | DW | Bus read data, valid with `bus_ready` |
| bus_ready | input | 1 | Bus completes the current transaction |

## Verification
Two decisions can land on the same edge: the retirement of the write on the bus, and the choice of what goes next. At that point an overtaking read, the next buffered write and a stalled new write all become eligible at once. The bench provokes this by holding `bus_ready` low while writes are pending and a read or a fifth write waits, and then releasing the bus. The bus-side log is then judged for the order of the completed transactions. The cycle of `core_done` is compared with the cycle in which the oldest write or the core's own transaction completed.

// File: rtl/pwf_pkg.sv
package pwf_pkg;

    // Ownership of the bus port.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_HEAD = 2'd1,
        ST_CORE = 2'd2
    } bus_state_e;

    // Ordering class of a core request.
    typedef enum logic [1:0] {
        CLS_POST      = 2'd0,
        CLS_SYNC_WR   = 2'd1,
        CLS_BYPASS_RD = 2'd2,
        CLS_ORDER_RD  = 2'd3
    } req_class_e;

endpackage

// File: rtl/pwf_classify.sv
module pwf_classify
    import pwf_pkg::*;
(
    input  logic       req_write,
    input  logic       req_io,
    input  logic       req_rep,
    input  logic       req_last,
    input  logic       req_cacheable,
    input  logic       addr_hit,
    output req_class_e req_class
);

    always_comb begin
        if (req_write) begin
            // Memory writes and non-final string I/O writes are posted.
            if (!req_io || (req_rep && !req_last)) begin
                req_class = CLS_POST;
            end else begin
                req_class = CLS_SYNC_WR;
            end
        end else begin
            if (!req_io && req_cacheable && !addr_hit) begin
                req_class = CLS_BYPASS_RD;
            end else begin
                req_class = CLS_ORDER_RD;
            end
        end
    end

endmodule

// File: rtl/pwf_queue.sv
module pwf_queue #(
    parameter int DEPTH = 4,
    parameter int AW    = 32,
    parameter int DW    = 32,
    localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [AW-1:0] push_addr,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    input  logic [AW-1:0] lookup_addr,
    output logic          lookup_hit,
    output logic [AW-1:0] head_addr,
    output logic [DW-1:0] head_data,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);

    typedef struct packed {
        logic [DEPTH-1:0][AW-1:0] addr;
        logic [DEPTH-1:0][DW-1:0] data;
        logic [DEPTH-1:0]         valid;
        logic [PW-1:0]            rd_ptr;
        logic [PW-1:0]            wr_ptr;
        logic [CW-1:0]            count;
    } q_state_t;

    q_state_t q_q, q_d;
    logic [DEPTH-1:0] hit_vec;

    function automatic logic [PW-1:0] ptr_step(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        q_d = q_q;
        if (push) begin
            q_d.addr[q_q.wr_ptr]  = push_addr;
            q_d.data[q_q.wr_ptr]  = push_data;
            q_d.valid[q_q.wr_ptr] = 1'b1;
            q_d.wr_ptr            = ptr_step(q_q.wr_ptr);
        end
        if (pop) begin
            q_d.valid[q_q.rd_ptr] = 1'b0;
            q_d.rd_ptr            = ptr_step(q_q.rd_ptr);
        end
        case ({push, pop})
            2'b10:   q_d.count = q_q.count + 1'b1;
            2'b01:   q_d.count = q_q.count - 1'b1;
            default: q_d.count = q_q.count;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q <= '0;
        end else begin
            q_q <= q_d;
        end
    end

    // One comparator per slot for the overtaking check.
    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign hit_vec[i] = q_q.valid[i] && (q_q.addr[i] == lookup_addr);
    end

    assign lookup_hit = |hit_vec;
    assign head_addr  = q_q.addr[q_q.rd_ptr];
    assign head_data  = q_q.data[q_q.rd_ptr];
    assign count      = q_q.count;
    assign full       = (q_q.count == CW'(DEPTH));
    assign empty      = (q_q.count == '0);

endmodule

// File: rtl/post_wr_fence.sv
module post_wr_fence
    import pwf_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DW    = 32,
    parameter int DEPTH = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          core_valid,
    input  logic          core_write,
    input  logic          core_io,
    input  logic          core_rep,
    input  logic          core_last,
    input  logic          core_cacheable,
    input  logic [AW-1:0] core_addr,
    input  logic [DW-1:0] core_wdata,
    output logic          core_done,
    output logic [DW-1:0] core_rdata,
    output logic          bus_req,
    output logic          bus_we,
    output logic [AW-1:0] bus_addr,
    output logic [DW-1:0] bus_wdata,
    input  logic [DW-1:0] bus_rdata,
    input  logic          bus_ready
);

    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        bus_state_e    st;
        logic          req;
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] wdata;
    } bus_reg_t;

    bus_reg_t   b_q, b_d;
    req_class_e req_class;
    logic       addr_hit;
    logic       q_push, q_pop, q_full, q_empty;
    logic [AW-1:0] head_addr;
    logic [DW-1:0] head_data;
    logic [CW-1:0] q_count;
    logic       bus_done;

    pwf_classify u_cls (
        .req_write     (core_write),
        .req_io        (core_io),
        .req_rep       (core_rep),
        .req_last      (core_last),
        .req_cacheable (core_cacheable),
        .addr_hit      (addr_hit),
        .req_class     (req_class)
    );

    pwf_queue #(
        .DEPTH (DEPTH),
        .AW    (AW),
        .DW    (DW)
    ) u_q (
        .clk         (clk),
        .rst_n       (rst_n),
        .push        (q_push),
        .push_addr   (core_addr),
        .push_data   (core_wdata),
        .pop         (q_pop),
        .lookup_addr (core_addr),
        .lookup_hit  (addr_hit),
        .head_addr   (head_addr),
        .head_data   (head_data),
        .count       (q_count),
        .full        (q_full),
        .empty       (q_empty)
    );

    assign bus_done = b_q.req && bus_ready;
    assign q_push   = core_valid && (req_class == CLS_POST) && !q_full;
    assign q_pop    = bus_done && (b_q.st == ST_HEAD);

    always_comb begin
        b_d = b_q;
        case (b_q.st)
            ST_IDLE: begin
                if (core_valid && (req_class == CLS_BYPASS_RD)) begin
                    // Overtaking read wins over the head write on an idle bus.
                    b_d.st    = ST_CORE;
                    b_d.req   = 1'b1;
                    b_d.we    = 1'b0;
                    b_d.addr  = core_addr;
                    b_d.wdata = '0;
                end else if (!q_empty) begin
                    b_d.st    = ST_HEAD;
                    b_d.req   = 1'b1;
                    b_d.we    = 1'b1;
                    b_d.addr  = head_addr;
                    b_d.wdata = head_data;
                end else if (core_valid &&
                             ((req_class == CLS_SYNC_WR) || (req_class == CLS_ORDER_RD))) begin
                    // Fenced request: buffer is empty, bus is free.
                    b_d.st    = ST_CORE;
                    b_d.req   = 1'b1;
                    b_d.we    = core_write;
                    b_d.addr  = core_addr;
                    b_d.wdata = core_write ? core_wdata : '0;
                end
            end
            ST_HEAD, ST_CORE: begin
                if (bus_ready) begin
                    b_d.st  = ST_IDLE;
                    b_d.req = 1'b0;
                end
            end
            default: begin
                b_d.st  = ST_IDLE;
                b_d.req = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            b_q <= '{st: ST_IDLE, req: 1'b0, we: 1'b0, addr: '0, wdata: '0};
        end else begin
            b_q <= b_d;
        end
    end

    assign core_done  = q_push || (bus_done && (b_q.st == ST_CORE));
    assign core_rdata = (b_q.st == ST_CORE) ? bus_rdata : '0;
    assign bus_req    = b_q.req;
    assign bus_we     = b_q.we;
    assign bus_addr   = b_q.addr;
    assign bus_wdata  = b_q.wdata;

endmodule

// File: rtl/pwf_chk.sv
module pwf_chk #(
    parameter int AW    = 32,
    parameter int DEPTH = 4,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          core_valid,
    input logic          core_write,
    input logic          core_io,
    input logic          core_rep,
    input logic          core_cacheable,
    input logic          core_done,
    input logic          bus_req,
    input logic          bus_we,
    input logic [AW-1:0] bus_addr,
    input logic          bus_ready,
    input logic [CW-1:0] q_count
);

    // R11
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && !bus_ready |=> bus_req && $stable(bus_addr) && $stable(bus_we));

    // R11
    one_txn_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req && bus_ready |=> !bus_req);

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q_count <= CW'(DEPTH));

    // R10
    full_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_valid && core_write && !core_io && (q_count == CW'(DEPTH)) |-> !core_done);

    // R8
    sync_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_valid && core_done && core_write && core_io && !core_rep
        |-> bus_req && bus_ready && bus_we && (q_count == '0));

    // R7
    io_rd_fence_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_valid && core_done && !core_write && core_io |-> q_count == '0);

    // R6
    nc_rd_fence_chk: assert property (@(posedge clk) disable iff (!rst_n)
        core_valid && core_done && !core_write && !core_cacheable |-> q_count == '0);

endmodule

bind post_wr_fence pwf_chk #(
    .AW    (AW),
    .DEPTH (DEPTH)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .core_valid     (core_valid),
    .core_write     (core_write),
    .core_io        (core_io),
    .core_rep       (core_rep),
    .core_cacheable (core_cacheable),
    .core_done      (core_done),
    .bus_req        (bus_req),
    .bus_we         (bus_we),
    .bus_addr       (bus_addr),
    .bus_ready      (bus_ready),
    .q_count        (q_count)
);

// File: tb/sim_post_wr_fence.sv
module sim_post_wr_fence;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int DEPTH = 4;
    localparam logic [31:0] RMASK = 32'hC3C3_0000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic          core_valid = 0, core_write = 0, core_io = 0, core_rep = 0;
    logic          core_last = 0, core_cacheable = 0;
    logic [AW-1:0] core_addr = '0;
    logic [DW-1:0] core_wdata = '0;
    logic          core_done;
    logic [DW-1:0] core_rdata;
    logic          bus_req, bus_we;
    logic [AW-1:0] bus_addr;
    logic [DW-1:0] bus_wdata;
    logic [DW-1:0] bus_rdata = '0;
    logic          bus_ready = 1'b0;
    logic          bus_hold = 1'b0;

    int nchk = 0;
    int nfail = 0;
    int cyc = 0;
    int log_n = 0;
    logic          log_we [64];
    logic [AW-1:0] log_addr [64];
    logic [DW-1:0] log_data [64];
    int            log_cyc [64];
    bit finished = 0;

    post_wr_fence #(.AW(AW), .DW(DW), .DEPTH(DEPTH)) u0 (
        .clk(clk), .rst_n(rst_n),
        .core_valid(core_valid), .core_write(core_write), .core_io(core_io),
        .core_rep(core_rep), .core_last(core_last), .core_cacheable(core_cacheable),
        .core_addr(core_addr), .core_wdata(core_wdata),
        .core_done(core_done), .core_rdata(core_rdata),
        .bus_req(bus_req), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_ready(bus_ready)
    );

    // Bus responder: completes one cycle after the request unless held.
    always @(negedge clk) begin
        bus_ready <= bus_req && !bus_hold;
        bus_rdata <= bus_addr ^ RMASK;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && bus_req && bus_ready && log_n < 64) begin
            log_we[log_n]   <= bus_we;
            log_addr[log_n] <= bus_addr;
            log_data[log_n] <= bus_wdata;
            log_cyc[log_n]  <= cyc;
            log_n <= log_n + 1;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic present(input bit w, input bit io, input bit rep, input bit last,
                           input bit cach, input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        core_valid = 1; core_write = w; core_io = io; core_rep = rep;
        core_last = last; core_cacheable = cach; core_addr = a; core_wdata = d;
    endtask

    // Waits for core_done; returns the cycle, read data and extra cycles waited.
    task automatic wait_done(input string tag, output int c, output logic [DW-1:0] rd, output int waited);
        int n = 0;
        #1;
        while (!core_done && n < 300) begin
            @(negedge clk); #1; n++;
        end
        chk(core_done, {tag, " done timeout"}, core_done, 1);
        c = cyc; rd = core_rdata; waited = n;
        @(negedge clk);
        core_valid = 0;
    endtask

    task automatic post(input bit io, input bit rep, input logic [AW-1:0] a,
                        input logic [DW-1:0] d, input string tag);
        int c, w; logic [DW-1:0] rd;
        present(1, io, rep, 0, 1, a, d);
        wait_done(tag, c, rd, w);
        chk(w == 0, {tag, " posted write acknowledged at once"}, w, 0);
    endtask

    task automatic stays_stalled(input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
            chk(!core_done, {tag, " core stalled"}, core_done, 0);
        end
    endtask

    task automatic release_bus();
        @(negedge clk); #1 bus_hold = 0;
    endtask

    task automatic settle();
        repeat (12) @(negedge clk);
    endtask

    task automatic chk_log(input int idx, input bit we, input logic [AW-1:0] a,
                           input logic [DW-1:0] d, input string tag);
        bit ok;
        ok = (idx < log_n) && (log_we[idx] == we) && (log_addr[idx] == a) &&
             (!we || (log_data[idx] == d));
        chk(ok, tag, (idx < log_n) ? log_addr[idx] : 32'hFFFF_FFFF, a);
    endtask

    task automatic t_reset();
        int b, c, w; logic [DW-1:0] rd;
        @(negedge clk);
        chk(!bus_req, "R1 bus_req in reset", bus_req, 0);
        chk(!core_done, "R1 core_done in reset", core_done, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);
        chk(!bus_req, "R1 bus_req after reset", bus_req, 0);
        b = log_n;
        present(0, 0, 0, 0, 0, 32'h0000_0040, 0);
        wait_done("R1", c, rd, w);
        settle();
        chk(log_n == b + 1, "R1 empty buffer: only the read on bus", log_n - b, 1);
        chk_log(b, 0, 32'h0000_0040, 0, "R1 first read alone");
        chk(rd == (32'h40 ^ RMASK), "R1 read data", rd, 32'h40 ^ RMASK);
    endtask

    task automatic t_order();
        int b;
        b = log_n;
        post(0, 0, 32'h100, 32'hAAAA_0001, "R2");
        post(0, 0, 32'h104, 32'hAAAA_0002, "R2");
        post(0, 0, 32'h108, 32'hAAAA_0003, "R2");
        settle();
        chk_log(b,     1, 32'h100, 32'hAAAA_0001, "R3 order 0");
        chk_log(b + 1, 1, 32'h104, 32'hAAAA_0002, "R3 order 1");
        chk_log(b + 2, 1, 32'h108, 32'hAAAA_0003, "R3 order 2");
        chk(log_cyc[b + 1] - log_cyc[b] >= 2, "R11 idle cycle between transactions",
            log_cyc[b + 1] - log_cyc[b], 2);
        chk(!bus_req, "R11 bus idle after drain", bus_req, 0);
    endtask

    task automatic t_bypass();
        int b, c, w; logic [DW-1:0] rd;
        b = log_n;
        @(negedge clk); bus_hold = 1;
        post(0, 0, 32'h200, 32'hB0, "R2");
        post(0, 0, 32'h204, 32'hB1, "R2");
        present(0, 0, 0, 0, 1, 32'h300, 0);
        stays_stalled(3, "R12");
        release_bus();
        wait_done("R4", c, rd, w);
        settle();
        chk_log(b,     1, 32'h200, 32'hB0, "R12 write in flight finishes first");
        chk_log(b + 1, 0, 32'h300, 0,      "R4 read overtakes pending write");
        chk_log(b + 2, 1, 32'h204, 32'hB1, "R4 pending write after read");
        chk(c == log_cyc[b + 1], "R4 done in bus completion cycle", c, log_cyc[b + 1]);
        chk(rd == (32'h300 ^ RMASK), "R4 read data", rd, 32'h300 ^ RMASK);
    endtask

    task automatic t_fenced_read(input bit io, input bit cach, input logic [AW-1:0] ra, input string tag);
        int b, c, w; logic [DW-1:0] rd;
        b = log_n;
        @(negedge clk); bus_hold = 1;
        post(0, 0, 32'h400, 32'hC0, tag);
        post(0, 0, 32'h404, 32'hC1, tag);
        present(0, io, 0, 0, cach, ra, 0);
        stays_stalled(3, tag);
        release_bus();
        wait_done(tag, c, rd, w);
        settle();
        chk_log(b,     1, 32'h400, 32'hC0, {tag, " first write drains"});
        chk_log(b + 1, 1, 32'h404, 32'hC1, {tag, " second write drains"});
        chk_log(b + 2, 0, ra, 0,           {tag, " read after drain"});
        chk(rd == (ra ^ RMASK), {tag, " read data"}, rd, ra ^ RMASK);
    endtask

    task automatic t_io_write();
        int b, c, w; logic [DW-1:0] rd;
        b = log_n;
        @(negedge clk); bus_hold = 1;
        post(0, 0, 32'h500, 32'hD0, "R2");
        present(1, 1, 0, 0, 0, 32'h0060, 32'hD1);
        stays_stalled(3, "R8");
        release_bus();
        wait_done("R8", c, rd, w);
        present(0, 0, 0, 0, 0, 32'h0508, 0);
        wait_done("R6", c, rd, w);
        settle();
        chk_log(b,     1, 32'h500, 32'hD0, "R8 earlier write first");
        chk_log(b + 1, 1, 32'h060, 32'hD1, "R8 io write on bus");
        chk_log(b + 2, 0, 32'h508, 0,      "R6 read after io write");
        chk(log_n == b + 3, "R8 io write issued once", log_n - b, 3);
    endtask

    task automatic t_rep();
        int b, c, w, cl; logic [DW-1:0] rd;
        b = log_n;
        @(negedge clk); bus_hold = 1;
        post(1, 1, 32'h70, 32'hE0, "R9");
        post(1, 1, 32'h70, 32'hE1, "R9");
        post(1, 1, 32'h70, 32'hE2, "R9");
        present(1, 1, 1, 1, 0, 32'h70, 32'hE3);
        stays_stalled(4, "R9");
        release_bus();
        wait_done("R9", c, rd, w);
        cl = log_cyc[b + 3];
        settle();
        chk_log(b,     1, 32'h70, 32'hE0, "R9 string 0");
        chk_log(b + 1, 1, 32'h70, 32'hE1, "R9 string 1");
        chk_log(b + 2, 1, 32'h70, 32'hE2, "R9 string 2");
        chk_log(b + 3, 1, 32'h70, 32'hE3, "R9 string last");
        chk(c == cl, "R9 release at last completion", c, cl);
    endtask

    task automatic t_full();
        int b, c, w; logic [DW-1:0] rd;
        b = log_n;
        @(negedge clk); bus_hold = 1;
        for (int i = 0; i < 4; i++) post(0, 0, 32'h800 + 4 * i, 32'hF0 + i, "R2");
        present(1, 0, 0, 0, 1, 32'h810, 32'hF4);
        stays_stalled(4, "R10");
        release_bus();
        wait_done("R10", c, rd, w);
        settle();
        chk(c == log_cyc[b] + 1, "R10 accepted cycle after first retire", c, log_cyc[b] + 1);
        for (int i = 0; i < 5; i++)
            chk_log(b + i, 1, 32'h800 + 4 * i, 32'hF0 + i, "R3 order after full");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            nfail++; nchk++;
            $display("FAIL watchdog R11 actual=%0h expected=%0h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_order();
        t_bypass();
        t_fenced_read(0, 1, 32'h404, "R5");
        t_fenced_read(0, 0, 32'h600, "R6");
        t_fenced_read(1, 0, 32'h0064, "R7");
        t_io_write();
        t_rep();
        t_full();
        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

endmodule